// File: doc/BRIEF.md
# Rotating Register Window Controller

This block holds a physical register file of `NAREG` 32-bit registers. Software sees only 16 of them at a time. The visible 16 form a window that starts at a group boundary, where a group is four physical registers. The current start group is held in a window-base register. A bitmap holds one bit per group and marks which groups begin a live call frame. The block carries out the windowed call-entry step, the windowed return, plain rotation, the pre-access spill check, the stack-pointer move check and restoring the base from the saved status field. Each operation completes in a single clock cycle.

A pipeline issues one operation per cycle on `op`, together with its operand fields and the current PC. Exception decisions appear on `exc_code` in the same cycle, combinationally. These include illegal operation, overflow and underflow of size 4, 8 or 12, and alloca. The return target appears on `ret_pc` in the same way. State updates take effect at the next rising clock edge. Three updates follow every exception: the status exception-mode bit is set, the PC is saved in `epc`, and for overflow and underflow the old window base is saved in the status old-base field. The exception handler code is outside this block, and so is the pipeline.

Top module: `win_regfile_ctrl`

## Requirements
- R1: Visible register r (0..15) maps to physical register (base*4 + r) mod NAREG. The two read ports are combinational through this mapping. When `wr_en` is high, the write port stores `wr_data` at the next edge, using the same mapping. An entry's own register write takes precedence over the write port.
- R2: After synchronous reset the window state and status are in a fixed initial state:
  - base is 0;
  - the start bitmap holds only bit 0;
  - overflow-enable, exception mode, call increment and old base are all 0;
  - `exc_code` is 0 while `op` is 0 (no-op).
- R3: Two operations load state directly from `op_val`.
  - Op 7 loads the status word: bit 0 is overflow-enable, bit 1 is exception mode, bits 3:2 are the call increment, and bits starting at 4 are the old base.
  - Op 8 loads the start bitmap from the low NAREG/4 bits.
- R4: Entry (op 1) is illegal in either of these cases. Illegal gives exc_code 7, sets exception mode and saves the PC, with no rotation and no register write.
  - `op_s` exceeds 3.
  - The status is not overflow-enable=1 with exception mode=0.
- R5: A legal entry does three things:
  - writes old-window register (callinc*4 + s) with R[s] − (`op_imm` << 3);
  - advances the base by callinc mod NAREG/4;
  - sets the start bit at the new base.
- R6: The spill check (op 4, w = `op_val[1:0]`) does nothing unless overflow-enable=1 and exception mode=0. It also does nothing when no start bit is set at base+1..base+w.
- R7: When the spill check finds the first set start bit at group base+n, it does four things:
  - rotates the base to base+n;
  - saves the old base into the status;
  - sets exception mode;
  - saves the PC.

  Let m be the new base. The code is 1 if the bit at m+1 is set, otherwise 2 if the bit at m+2 is set, otherwise 3.
- R8: Return (op 2) takes n from bits 31:30 of visible register 0. It takes m as the first k in 1..3 with the start bit at base−k set, or 0 if there is none. The return is illegal (code 7, exception mode set, PC saved, no rotation) in any of these cases:
  - n = 0;
  - m ≠ 0 and m ≠ n;
  - the overflow-enable/exception-mode condition fails.
- R9: A legal return does three things:
  - raises `ret_valid`;
  - drives `ret_pc` = {PC[31:30], R0[29:0]};
  - moves the base to base−n.

  If the start bit at the new base is set, the start bit of the old base is cleared.
- R10: If the start bit at the post-return base is clear, the return raises underflow codes 4, 5 or 6 for n = 1, 2 or 3. It also saves the old base into the status, sets exception mode and saves the PC.
- R11: The stack-pointer move check (op 5) gives code 8 when none of the start bits at base−1, base−2 and base−3 is set. In that case it also sets exception mode and saves the PC. Otherwise it gives code 0.
- R12: Rotate (op 3) adds the 4-bit two's-complement value `op_val[3:0]` to the base mod NAREG/4. Restore (op 6) sets the base to the status old-base field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (0 no-op, 1 entry, 2 return, 3 rotate, 4 spill check, 5 stack-pointer check, 6 restore, 7 status load, 8 bitmap load) |
| op_s | input | 4 | Stack register field for entry |
| op_imm | input | 12 | Frame size immediate for entry, in 8-byte units |
| op_val | input | 32 | Generic operand: rotate delta, check width, status or bitmap value |
| pc_in | input | 32 | PC of the current operation |
| rd_a_idx | input | 4 | Visible index, read port A |
| rd_b_idx | input | 4 | Visible index, read port B |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Visible index, write port |
| wr_data | input | 32 | Write port data |
| exc_code | output | 4 | Exception raised by the current operation (0 none) |
| ret_valid | output | 1 | Current operation is a legal return |
| ret_pc | output | 32 | Return target |
| win_base | output | log2(NAREG/4) | Current window base |
| win_start | output | NAREG/4 | Window start bitmap |
| ps_woe | output | 1 | Status overflow-enable |
| ps_excm | output | 1 | Status exception mode |
| ps_callinc | output | 2 | Status call increment |
| ps_owb | output | log2(NAREG/4) | Status old window base |
| epc | output | 32 | Saved PC |

## Verification
The bench builds the block with NAREG = 32, which gives eight groups and a three-bit base. With only eight groups, a single negative rotation wraps the base from 0 to 7. The same small size lets the return and stack-pointer checks look below group 0 into groups 5 to 7. The visible-to-physical mapping is confirmed across the wrap by reading a value written before rotation. Every overflow and underflow size is reached by loading a chosen bitmap and status word directly.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int XLEN = 32;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ENTRY   = 4'd1,
        OP_RETW    = 4'd2,
        OP_ROTW    = 4'd3,
        OP_CHECK   = 4'd4,
        OP_MOVSP   = 4'd5,
        OP_RESTORE = 4'd6,
        OP_WRPS    = 4'd7,
        OP_WRWS    = 4'd8
    } op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_OVF4    = 4'd1,
        EXC_OVF8    = 4'd2,
        EXC_OVF12   = 4'd3,
        EXC_UNF4    = 4'd4,
        EXC_UNF8    = 4'd5,
        EXC_UNF12   = 4'd6,
        EXC_ILLEGAL = 4'd7,
        EXC_ALLOCA  = 4'd8
    } exc_e;

    typedef struct packed {
        logic       woe;
        logic       excm;
        logic [1:0] callinc;
    } ps_t;

    function automatic logic windowed_ok(input ps_t ps);
        return ps.woe && !ps.excm;
    endfunction

endpackage

// File: rtl/wrf_regs.sv
module wrf_regs
    import wrf_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NAREG),
    localparam int WBW  = AW - 2
) (
    input  logic            clk,
    input  logic [WBW-1:0]  base,
    input  logic [3:0]      ridx  [NRD],
    output logic [XLEN-1:0] rdata [NRD],
    input  logic            we,
    input  logic [3:0]      widx,
    input  logic [XLEN-1:0] wdata
);

    logic [XLEN-1:0] mem [NAREG];

    function automatic logic [AW-1:0] to_phys(input logic [WBW-1:0] b, input logic [3:0] r);
        return {b, 2'b00} + AW'(r);
    endfunction

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[to_phys(base, ridx[g])];
    end

    always_ff @(posedge clk) begin
        if (we) mem[to_phys(base, widx)] <= wdata;
    end

endmodule

// File: rtl/wrf_window.sv
module wrf_window
    import wrf_pkg::*;
#(
    parameter int NGRP = 16,
    localparam int WBW = $clog2(NGRP)
) (
    input  op_e             op,
    input  logic [3:0]      s,
    input  logic [11:0]     imm,
    input  logic [XLEN-1:0] val,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] r0_val,
    input  logic [WBW-1:0]  base,
    input  logic [NGRP-1:0] ws,
    input  ps_t             ps,
    input  logic [WBW-1:0]  owb,
    output logic [WBW-1:0]  nxt_base,
    output logic [NGRP-1:0] nxt_ws,
    output ps_t             nxt_ps,
    output logic [WBW-1:0]  nxt_owb,
    output logic            epc_we,
    output exc_e            exc,
    output logic            ret_valid,
    output logic [XLEN-1:0] ret_pc,
    output logic            ent_we,
    output logic [3:0]      ent_vidx,
    output logic [XLEN-1:0] ent_data
);

    logic           legal;
    logic           found;
    logic [1:0]     n;
    logic [1:0]     m;
    logic [1:0]     w;
    logic [WBW-1:0] t;
    logic [WBW+3:0] delta;

    assign legal = windowed_ok(ps);
    assign w     = val[1:0];
    assign delta = {{WBW{val[3]}}, val[3:0]};

    always_comb begin
        nxt_base  = base;
        nxt_ws    = ws;
        nxt_ps    = ps;
        nxt_owb   = owb;
        epc_we    = 1'b0;
        exc       = EXC_NONE;
        ret_valid = 1'b0;
        ret_pc    = '0;
        ent_we    = 1'b0;
        ent_vidx  = '0;
        ent_data  = '0;
        found     = 1'b0;
        n         = '0;
        m         = '0;
        t         = '0;
        unique case (op)
            OP_ENTRY: begin
                if (s > 4'd3 || !legal) begin
                    exc         = EXC_ILLEGAL;
                    nxt_ps.excm = 1'b1;
                    epc_we      = 1'b1;
                end else begin
                    ent_we   = 1'b1;
                    ent_vidx = {ps.callinc, s[1:0]};
                    ent_data = rs_val - (XLEN'(imm) << 3);
                    t        = base + WBW'(ps.callinc);
                    nxt_base = t;
                    nxt_ws[t] = 1'b1;
                end
            end
            OP_CHECK: begin
                if (legal) begin
                    for (int k = 1; k <= 3; k++) begin
                        if (!found && (k <= int'(w)) && ws[WBW'(base + WBW'(k))]) begin
                            found = 1'b1;
                            n     = 2'(k);
                        end
                    end
                    if (found) begin
                        t           = base + WBW'(n);
                        nxt_base    = t;
                        nxt_owb     = base;
                        nxt_ps.excm = 1'b1;
                        epc_we      = 1'b1;
                        if (ws[WBW'(t + WBW'(1))])      exc = EXC_OVF4;
                        else if (ws[WBW'(t + WBW'(2))]) exc = EXC_OVF8;
                        else                            exc = EXC_OVF12;
                    end
                end
            end
            OP_RETW: begin
                n = r0_val[31:30];
                for (int k = 1; k <= 3; k++) begin
                    if (!found && ws[WBW'(base - WBW'(k))]) begin
                        found = 1'b1;
                        m     = 2'(k);
                    end
                end
                if (n == 2'd0 || (m != 2'd0 && m != n) || !legal) begin
                    exc         = EXC_ILLEGAL;
                    nxt_ps.excm = 1'b1;
                    epc_we      = 1'b1;
                end else begin
                    ret_valid = 1'b1;
                    ret_pc    = {pc[31:30], r0_val[29:0]};
                    t         = base - WBW'(n);
                    nxt_base  = t;
                    if (ws[t]) begin
                        nxt_ws[base] = 1'b0;
                    end else begin
                        nxt_owb     = base;
                        nxt_ps.excm = 1'b1;
                        epc_we      = 1'b1;
                        exc         = exc_e'(4'd3 + 4'(n));
                    end
                end
            end
            OP_ROTW:    nxt_base = base + delta[WBW-1:0];
            OP_MOVSP: begin
                if (!(ws[WBW'(base - WBW'(1))] || ws[WBW'(base - WBW'(2))] ||
                      ws[WBW'(base - WBW'(3))])) begin
                    exc         = EXC_ALLOCA;
                    nxt_ps.excm = 1'b1;
                    epc_we      = 1'b1;
                end
            end
            OP_RESTORE: nxt_base = owb;
            OP_WRPS: begin
                nxt_ps.woe     = val[0];
                nxt_ps.excm    = val[1];
                nxt_ps.callinc = val[3:2];
                nxt_owb        = val[4 +: WBW];
            end
            OP_WRWS:    nxt_ws = val[NGRP-1:0];
            default: ;
        endcase
    end

endmodule

// File: rtl/win_regfile_ctrl.sv
module win_regfile_ctrl
    import wrf_pkg::*;
#(
    parameter int NAREG = 64,
    localparam int NGRP = NAREG / 4,
    localparam int WBW  = $clog2(NGRP)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op,
    input  logic [3:0]      op_s,
    input  logic [11:0]     op_imm,
    input  logic [31:0]     op_val,
    input  logic [31:0]     pc_in,
    input  logic [3:0]      rd_a_idx,
    input  logic [3:0]      rd_b_idx,
    output logic [31:0]     rd_a_data,
    output logic [31:0]     rd_b_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [31:0]     wr_data,
    output logic [3:0]      exc_code,
    output logic            ret_valid,
    output logic [31:0]     ret_pc,
    output logic [WBW-1:0]  win_base,
    output logic [NGRP-1:0] win_start,
    output logic            ps_woe,
    output logic            ps_excm,
    output logic [1:0]      ps_callinc,
    output logic [WBW-1:0]  ps_owb,
    output logic [31:0]     epc
);

    op_e             op_c;
    logic [WBW-1:0]  base_q, base_d, owb_q, owb_d;
    logic [NGRP-1:0] ws_q, ws_d;
    ps_t             ps_q, ps_d;
    logic [XLEN-1:0] epc_q;
    logic            epc_we;
    exc_e            exc;
    logic            ent_we;
    logic [3:0]      ent_vidx;
    logic [XLEN-1:0] ent_data;
    logic [3:0]      ridx  [3];
    logic [XLEN-1:0] rdata [3];

    assign op_c    = op_e'(op);
    assign ridx[0] = rd_a_idx;
    assign ridx[1] = rd_b_idx;
    assign ridx[2] = (op_c == OP_ENTRY) ? op_s : 4'd0;

    wrf_regs #(.NAREG(NAREG), .NRD(3)) u_regs (
        .clk   (clk),
        .base  (base_q),
        .ridx  (ridx),
        .rdata (rdata),
        .we    (ent_we || wr_en),
        .widx  (ent_we ? ent_vidx : wr_idx),
        .wdata (ent_we ? ent_data : wr_data)
    );

    wrf_window #(.NGRP(NGRP)) u_win (
        .op        (op_c),
        .s         (op_s),
        .imm       (op_imm),
        .val       (op_val),
        .pc        (pc_in),
        .rs_val    (rdata[2]),
        .r0_val    (rdata[2]),
        .base      (base_q),
        .ws        (ws_q),
        .ps        (ps_q),
        .owb       (owb_q),
        .nxt_base  (base_d),
        .nxt_ws    (ws_d),
        .nxt_ps    (ps_d),
        .nxt_owb   (owb_d),
        .epc_we    (epc_we),
        .exc       (exc),
        .ret_valid (ret_valid),
        .ret_pc    (ret_pc),
        .ent_we    (ent_we),
        .ent_vidx  (ent_vidx),
        .ent_data  (ent_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ws_q   <= NGRP'(1);
            ps_q   <= '0;
            owb_q  <= '0;
            epc_q  <= '0;
        end else begin
            base_q <= base_d;
            ws_q   <= ws_d;
            ps_q   <= ps_d;
            owb_q  <= owb_d;
            if (epc_we) epc_q <= pc_in;
        end
    end

    assign rd_a_data  = rdata[0];
    assign rd_b_data  = rdata[1];
    assign exc_code   = exc;
    assign win_base   = base_q;
    assign win_start  = ws_q;
    assign ps_woe     = ps_q.woe;
    assign ps_excm    = ps_q.excm;
    assign ps_callinc = ps_q.callinc;
    assign ps_owb     = owb_q;
    assign epc        = epc_q;

    // R4 / R8: an illegal operation always leaves exception mode set
    a_r4_illegal_sets_excm: assert property (@(posedge clk) disable iff (rst)
        (exc_code == 4'd7) |=> ps_excm);

    // R7: a spill trap saves the old base and enters exception mode
    a_r7_ovf_saves_base: assert property (@(posedge clk) disable iff (rst)
        (exc_code inside {4'd1, 4'd2, 4'd3}) |=> (ps_excm && ps_owb == $past(win_base)));

    // R6: no spill trap outside the windowed mode
    a_r6_check_quiet: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd4 && !(ps_woe && !ps_excm)) |-> (exc_code == 4'd0));

    // R9: return target keeps the PC's top two bits
    a_r9_ret_region: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> (ret_pc[31:30] == pc_in[31:30]));

    // R12: restore takes the saved base
    a_r12_restore_base: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd6) |=> (win_base == $past(ps_owb)));

    // R1: the base holds still across a no-op
    a_r1_nop_keeps_base: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd0) |=> $stable(win_base));

endmodule

// File: tb/sim_win_regfile_ctrl.sv
`timescale 1ns/1ps
module sim_win_regfile_ctrl;

    localparam int NAREG = 32;
    localparam int NGRP  = NAREG / 4;
    localparam int WBW   = $clog2(NGRP);

    localparam logic [3:0] NOP = 4'd0, ENTRY = 4'd1, RETW = 4'd2, ROTW = 4'd3,
                           CHECK = 4'd4, MOVSP = 4'd5, RESTORE = 4'd6,
                           WRPS = 4'd7, WRWS = 4'd8;

    logic clk = 1'b0;
    logic rst;
    logic [3:0] op, op_s, rd_a_idx, rd_b_idx, wr_idx;
    logic [11:0] op_imm;
    logic [31:0] op_val, pc_in, wr_data;
    logic wr_en;
    logic [31:0] rd_a_data, rd_b_data, ret_pc, epc;
    logic [3:0] exc_code;
    logic ret_valid, ps_woe, ps_excm;
    logic [1:0] ps_callinc;
    logic [WBW-1:0] win_base, ps_owb;
    logic [NGRP-1:0] win_start;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  c_exc;
    logic        c_rv;
    logic [31:0] c_rpc;

    always #10 clk = ~clk;

    win_regfile_ctrl #(.NAREG(NAREG)) u0 (
        .clk(clk), .rst(rst), .op(op), .op_s(op_s), .op_imm(op_imm), .op_val(op_val),
        .pc_in(pc_in), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_a_data(rd_a_data),
        .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_code(exc_code), .ret_valid(ret_valid), .ret_pc(ret_pc), .win_base(win_base),
        .win_start(win_start), .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc),
        .ps_owb(ps_owb), .epc(epc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one operation: outputs captured before the edge, state visible after it
    task automatic run_op(input logic [3:0] o, input logic [3:0] s, input logic [11:0] imm,
                          input logic [31:0] v, input logic [31:0] pc);
        @(negedge clk);
        op = o; op_s = s; op_imm = imm; op_val = v; pc_in = pc;
        #2;
        c_exc = exc_code; c_rv = ret_valid; c_rpc = ret_pc;
        @(posedge clk); #1;
        op = NOP;
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        rd_a_idx = idx; #1;
        d = rd_a_data;
    endtask

    // status word: bit0 woe, bit1 excm, bits3:2 callinc, bits from 4 old base
    function automatic logic [31:0] psw(input logic woe, input logic excm, input logic [1:0] ci,
                                        input logic [WBW-1:0] ob);
        return 32'(woe) | (32'(excm) << 1) | (32'(ci) << 2) | (32'(ob) << 4);
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R2", "base", 32'(win_base), 0);
        chk("R2", "start map", 32'(win_start), 32'h01);
        chk("R2", "woe/excm", {30'd0, ps_woe, ps_excm}, 0);
        chk("R2", "owb/callinc", {ps_owb, ps_callinc}, 0);
        chk("R2", "exc idle", 32'(exc_code), 0);
    endtask

    task automatic t_map_rotate;
        logic [31:0] d;
        wr_reg(4'd5, 32'hA5A5_0005);
        rd_reg(4'd5, d);      chk("R1", "read back r5", d, 32'hA5A5_0005);
        run_op(ROTW, 0, 0, 32'h1, 0);
        chk("R12", "rotate +1", 32'(win_base), 1);
        rd_reg(4'd1, d);      chk("R1", "r1 at base1 is phys5", d, 32'hA5A5_0005);
        run_op(ROTW, 0, 0, 32'hF, 0);
        run_op(ROTW, 0, 0, 32'hF, 0);
        chk("R12", "rotate wraps to top", 32'(win_base), NGRP - 1);
        rd_reg(4'd9, d);      chk("R1", "r9 at base7 wraps to phys5", d, 32'hA5A5_0005);
        run_op(ROTW, 0, 0, 32'h1, 0);
        chk("R12", "rotate back to 0", 32'(win_base), 0);
    endtask

    task automatic t_illegal_entry;
        run_op(ENTRY, 4'd1, 12'd1, 0, 32'h0000_1000);
        chk("R4", "entry with woe=0 illegal", 32'(c_exc), 7);
        chk("R4", "excm set", 32'(ps_excm), 1);
        chk("R4", "epc saved", epc, 32'h0000_1000);
        chk("R4", "no rotation", 32'(win_base), 0);
        run_op(WRPS, 0, 0, psw(1, 0, 2'd1, 0), 0);
        run_op(ENTRY, 4'd4, 12'd1, 0, 32'h0000_1004);
        chk("R4", "entry with s=4 illegal", 32'(c_exc), 7);
        chk("R4", "s=4 no rotation", 32'(win_base), 0);
        chk("R3", "status load woe", 32'(ps_woe), 1);
    endtask

    task automatic t_entry;
        logic [31:0] d;
        run_op(WRPS, 0, 0, psw(1, 0, 2'd2, 0), 0);
        chk("R3", "status callinc", 32'(ps_callinc), 2);
        wr_reg(4'd1, 32'd1000);
        run_op(ENTRY, 4'd1, 12'd5, 0, 32'h0000_2000);
        chk("R5", "legal entry exc", 32'(c_exc), 0);
        chk("R5", "base advanced by callinc", 32'(win_base), 2);
        chk("R5", "start bit set at new base", 32'(win_start), 32'h05);
        rd_reg(4'd1, d);
        chk("R5", "new r1 = old r9 = 1000-40", d, 32'd960);
    endtask

    task automatic t_return;
        wr_reg(4'd0, 32'h8000_0123);
        run_op(RETW, 0, 0, 0, 32'hC000_0010);
        chk("R9", "legal return exc", 32'(c_exc), 0);
        chk("R9", "ret_valid", 32'(c_rv), 1);
        chk("R9", "ret_pc", c_rpc, 32'hC000_0123);
        chk("R9", "base back by n", 32'(win_base), 0);
        chk("R9", "old base bit cleared", 32'(win_start), 32'h01);
        wr_reg(4'd0, 32'h0000_0100);
        run_op(RETW, 0, 0, 0, 32'h0000_3000);
        chk("R8", "n=0 illegal", 32'(c_exc), 7);
        chk("R8", "n=0 no ret", 32'(c_rv), 0);
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(WRWS, 0, 0, 32'h41, 0);
        wr_reg(4'd0, 32'h4000_0000);
        run_op(RETW, 0, 0, 0, 32'h0000_3004);
        chk("R8", "m=2 vs n=1 illegal", 32'(c_exc), 7);
        chk("R8", "illegal no rotation", 32'(win_base), 0);
    endtask

    task automatic t_underflow;
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(WRWS, 0, 0, 32'h01, 0);
        run_op(RETW, 0, 0, 0, 32'h0000_4000);
        chk("R10", "underflow n=1 code", 32'(c_exc), 4);
        chk("R10", "base rotated to 7", 32'(win_base), 7);
        chk("R10", "owb saved", 32'(ps_owb), 0);
        chk("R10", "excm set", 32'(ps_excm), 1);
        chk("R10", "epc", epc, 32'h0000_4000);
        run_op(RESTORE, 0, 0, 0, 0);
        chk("R12", "restore to owb", 32'(win_base), 0);
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        wr_reg(4'd0, 32'hC000_0000);
        run_op(RETW, 0, 0, 0, 32'h0000_4004);
        chk("R10", "underflow n=3 code", 32'(c_exc), 6);
        chk("R10", "base 5", 32'(win_base), 5);
    endtask

    task automatic t_overflow;
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(RESTORE, 0, 0, 0, 0);
        run_op(WRWS, 0, 0, 32'h0C, 0);
        run_op(CHECK, 0, 0, 32'd3, 32'h0000_5000);
        chk("R7", "overflow-4 code", 32'(c_exc), 1);
        chk("R7", "base rotated by 2", 32'(win_base), 2);
        chk("R7", "owb saved", 32'(ps_owb), 0);
        chk("R7", "epc", epc, 32'h0000_5000);
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(RESTORE, 0, 0, 0, 0);
        run_op(WRWS, 0, 0, 32'h14, 0);
        run_op(CHECK, 0, 0, 32'd3, 0);
        chk("R7", "overflow-8 code", 32'(c_exc), 2);
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(RESTORE, 0, 0, 0, 0);
        run_op(WRWS, 0, 0, 32'h04, 0);
        run_op(CHECK, 0, 0, 32'd3, 0);
        chk("R7", "overflow-12 code", 32'(c_exc), 3);
        run_op(WRPS, 0, 0, psw(1, 0, 0, 0), 0);
        run_op(RESTORE, 0, 0, 0, 0);
        run_op(WRWS, 0, 0, 32'h04, 0);
        run_op(CHECK, 0, 0, 32'd1, 0);
        chk("R6", "bit beyond w gives no trap", 32'(c_exc), 0);
        chk("R6", "base unchanged", 32'(win_base), 0);
        run_op(WRPS, 0, 0, psw(1, 1, 0, 0), 0);
        run_op(WRWS, 0, 0, 32'h02, 0);
        run_op(CHECK, 0, 0, 32'd3, 0);
        chk("R6", "excm=1 gives no trap", 32'(c_exc), 0);
        chk("R6", "excm=1 base unchanged", 32'(win_base), 0);
    endtask

    task automatic t_movsp;
        run_op(WRWS, 0, 0, 32'h01, 0);
        run_op(MOVSP, 0, 0, 0, 32'h0000_6000);
        chk("R11", "alloca when no caller bits", 32'(c_exc), 8);
        chk("R11", "epc", epc, 32'h0000_6000);
        run_op(WRWS, 0, 0, 32'h21, 0);
        run_op(MOVSP, 0, 0, 0, 0);
        chk("R11", "no alloca with bit at base-3", 32'(c_exc), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op = NOP; op_s = 0; op_imm = 0; op_val = 0; pc_in = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_map_rotate();
        t_illegal_entry();
        t_entry();
        t_return();
        t_underflow();
        t_overflow();
        t_movsp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule